// File: doc/BRIEF.md
# Dual-Side Auto-Indexed Byte Buffer

This block is a small byte store with two independent ways in. On one side sits the byte layer of an I2C target. That layer has already decoded the bus and hands over single-cycle events: bus start or restart, own-address match with its direction, a received data byte, a request for a byte to send, and bus stop. On the other side a local processor reaches the same storage through two registers. One is a base-offset register and the other is a data window. Each side keeps its own base offset and its own running position, so neither has to send an address with every byte.

In a write transaction from the bus master, the first data byte names where the burst starts and is not stored. Every later byte lands at the running position, which then steps forward. In a read transaction the running position restarts at the stored base, so a master can select an offset once and read the same region again and again. The processor sets its base the same way and then streams bytes through the data window. The storage has one port. When both sides want it in the same cycle the bus side wins, and the processor request waits on a ready signal.

Top module: `ptr_regbuf`

## Requirements
- R1: The buffer holds DEPTH (default 32) bytes that read as 0x00 after reset. A byte written by either side can be read back by the other side.
- R2: After an address match with i2c_dir_rd=0, the first i2c_rx_valid byte is not stored. It loads the bus-side base offset and running position together.
- R3: Each later i2c_rx_valid byte of that transaction is written at the bus-side running position, and the position then steps by one. Offset 2 followed by four bytes fills locations 2..5.
- R4: An i2c_tx_req during a read transaction (address match with i2c_dir_rd=1) returns the byte at the bus-side running position on i2c_tx_byte. i2c_tx_valid is high in the cycle after the request, and the position then steps by one.
- R5: Every address match with i2c_dir_rd=1 reloads the bus-side running position from the bus-side base offset, so a repeated read starts at the same location.
- R6: A pulse on cpu_base_we loads cpu_wdata into the processor-side base offset and running position together.
- R7: A processor data access (cpu_req, cpu_we selects write) completes in the cycle where cpu_ready is high. It reads or writes the location at the processor running position, and that position steps by one. Read data appears on cpu_rdata with cpu_rvalid high one cycle after completion.
- R8: On both sides the running position stops at an end mark one past the last location (31). At the end mark reads return 0xFF and writes are dropped.
- R9: An offset value of DEPTH or more, from the bus offset byte or from cpu_base_we, is clamped to DEPTH-1.
- R10: In a cycle where the bus side accesses the storage (a stored rx byte or an accepted tx request), cpu_ready is low. The processor keeps cpu_req high until cpu_ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2c_start | input | 1 | Start or repeated start seen on the bus |
| i2c_stop | input | 1 | Stop seen on the bus |
| i2c_addr_hit | input | 1 | Own target address matched |
| i2c_dir_rd | input | 1 | Direction bit qualifying i2c_addr_hit (1 = master reads) |
| i2c_rx_valid | input | 1 | Received data byte strobe |
| i2c_rx_byte | input | 8 | Received data byte |
| i2c_tx_req | input | 1 | Request for the next byte to send |
| i2c_tx_byte | output | 8 | Byte to send, valid with i2c_tx_valid |
| i2c_tx_valid | output | 1 | Byte to send is ready |
| cpu_base_we | input | 1 | Write cpu_wdata into the processor base offset |
| cpu_req | input | 1 | Processor data window access request |
| cpu_we | input | 1 | 1 = data window write, 0 = read |
| cpu_wdata | input | 8 | Processor write data or base offset |
| cpu_ready | output | 1 | Data window access completes this cycle |
| cpu_rdata | output | 8 | Data window read data |
| cpu_rvalid | output | 1 | cpu_rdata is valid |

## Verification
A wrong running position shows on the very next data byte. A read returns the neighbouring location's contents, or a false 0xFF near the end of the buffer. A misplaced write only shows when that location is read later, so the sequence reads every written region back from the opposite side. A broken reload or clamp shows in the first byte of the following read burst. A bad arbitration decision shows in the same cycle as a high cpu_ready during a bus access.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OFS  = 2'd1,
    PH_WR   = 2'd2,
    PH_RD   = 2'd3
  } bus_phase_t;

  // Step a running position, holding at the end mark (== depth).
  function automatic int step_pos(input int pos, input int depth);
    return (pos >= depth) ? depth : pos + 1;
  endfunction

  // Offsets beyond the buffer fold onto the last location.
  function automatic int clamp_offset(input int ofs, input int depth);
    return (ofs >= depth) ? depth - 1 : ofs;
  endfunction

endpackage

// File: rtl/regbuf_mem.sv
module regbuf_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [PW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cpu_en,
  input  logic          cpu_we,
  input  logic [PW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DW-1:0] PAST_END = {DW{1'b1}};

  logic [DW-1:0] cells [DEPTH];

  wire bus_in_range = (int'(bus_addr) < DEPTH);
  wire cpu_in_range = (int'(cpu_addr) < DEPTH);
  wire [AW-1:0] bus_idx = bus_addr[AW-1:0];
  wire [AW-1:0] cpu_idx = cpu_addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      if (bus_we && bus_in_range)
        cells[bus_idx] <= bus_wdata;
      else if (cpu_en && cpu_we && cpu_in_range)
        cells[cpu_idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      cpu_rdata <= '0;
    end else begin
      if (bus_re) bus_rdata <= bus_in_range ? cells[bus_idx] : PAST_END;
      if (cpu_en && !cpu_we) cpu_rdata <= cpu_in_range ? cells[cpu_idx] : PAST_END;
    end
  end

  // R10: the single storage port is never claimed by both sides at once.
  assert_single_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_en && (bus_we || bus_re)));

endmodule

// File: rtl/regbuf_bus_side.sv
module regbuf_bus_side #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          addr_hit,
  input  logic          dir_rd,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_req,
  output logic          mem_we,
  output logic          mem_re,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          tx_valid,
  output logic          busy
);
  import regbuf_pkg::*;

  bus_phase_t    phase_q;
  logic [PW-1:0] base_q, pos_q;

  // Named internal events.
  wire ofs_load  = rx_valid && (phase_q == PH_OFS);
  wire wr_byte   = rx_valid && (phase_q == PH_WR);
  wire rd_byte   = tx_req   && (phase_q == PH_RD);
  wire rd_reload = addr_hit && dir_rd;
  wire wr_begin  = addr_hit && !dir_rd;

  wire [PW-1:0] ofs_clamped = PW'(clamp_offset(int'(rx_byte), DEPTH));
  wire [PW-1:0] pos_next    = PW'(step_pos(int'(pos_q), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      base_q  <= '0;
      pos_q   <= '0;
    end else begin
      if (rd_reload) begin
        phase_q <= PH_RD;
        pos_q   <= base_q;
      end else if (wr_begin) begin
        phase_q <= PH_OFS;
      end else if (start || stop) begin
        phase_q <= PH_IDLE;
      end else if (ofs_load) begin
        phase_q <= PH_WR;
        base_q  <= ofs_clamped;
        pos_q   <= ofs_clamped;
      end else if (wr_byte || rd_byte) begin
        pos_q   <= pos_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= rd_byte && !rd_reload && !wr_begin && !start && !stop;
  end

  wire ctl_event = rd_reload || wr_begin || start || stop;
  assign mem_we    = wr_byte && !ctl_event;
  assign mem_re    = rd_byte && !ctl_event;
  assign mem_addr  = pos_q;
  assign mem_wdata = rx_byte;
  assign busy      = mem_we || mem_re;

  // R2: the offset byte sets base and position to the same value.
  assert_ofs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_load && !ctl_event) |=> (base_q == pos_q));
  // R9: a loaded offset always points inside the buffer.
  assert_ofs_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_load && !ctl_event) |=> (int'(pos_q) < DEPTH));
  // R3: a stored byte inside the buffer advances the position by one.
  assert_wr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && int'(pos_q) < DEPTH) |=> (int'(pos_q) == int'($past(pos_q)) + 1));
  // R4: an accepted send request yields a byte the next cycle.
  assert_tx_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> tx_valid);
  // R5: a read-direction match restarts at the base offset.
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reload |=> (pos_q == base_q));
  // R8: the position never passes the end mark.
  assert_pos_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) <= DEPTH);

endmodule

// File: rtl/regbuf_cpu_side.sv
module regbuf_cpu_side #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic          req,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          grant,
  output logic          access_req,
  output logic [PW-1:0] mem_addr,
  output logic          rvalid
);
  import regbuf_pkg::*;

  logic [PW-1:0] base_q, pos_q;

  wire [PW-1:0] base_clamped = PW'(clamp_offset(int'(wdata), DEPTH));
  wire [PW-1:0] pos_next     = PW'(step_pos(int'(pos_q), DEPTH));
  wire          rd_done      = grant && !we;

  assign access_req = req && !base_we;
  assign mem_addr   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      pos_q  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_done;
      if (base_we) begin
        base_q <= base_clamped;
        pos_q  <= base_clamped;
      end else if (grant) begin
        pos_q  <= pos_next;
      end
    end
  end

  // R6: a base write moves the running position onto the base.
  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (pos_q == base_q));
  // R7: a completed read returns data one cycle later.
  assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rvalid);
  // R7: a completed access advances the position unless it sits at the end.
  assert_cpu_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && int'(pos_q) < DEPTH) |=> (int'(pos_q) == int'($past(pos_q)) + 1));
  // R8: the position never passes the end mark.
  assert_cpu_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) <= DEPTH);

endmodule

// File: rtl/ptr_regbuf.sv
module ptr_regbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i2c_start,
  input  logic          i2c_stop,
  input  logic          i2c_addr_hit,
  input  logic          i2c_dir_rd,
  input  logic          i2c_rx_valid,
  input  logic [DW-1:0] i2c_rx_byte,
  input  logic          i2c_tx_req,
  output logic [DW-1:0] i2c_tx_byte,
  output logic          i2c_tx_valid,
  input  logic          cpu_base_we,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid
);
  localparam int PW = $clog2(DEPTH) + 1;

  logic          bus_we, bus_re, bus_busy;
  logic [PW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          cpu_access_req, cpu_grant;
  logic [PW-1:0] cpu_addr;

  regbuf_bus_side #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .start(i2c_start), .stop(i2c_stop),
    .addr_hit(i2c_addr_hit), .dir_rd(i2c_dir_rd),
    .rx_valid(i2c_rx_valid), .rx_byte(i2c_rx_byte),
    .tx_req(i2c_tx_req),
    .mem_we(bus_we), .mem_re(bus_re), .mem_addr(bus_addr), .mem_wdata(bus_wdata),
    .tx_valid(i2c_tx_valid), .busy(bus_busy)
  );

  // Bus side first: the processor waits whenever the bus touches storage.
  assign cpu_grant = cpu_access_req && !bus_busy;
  assign cpu_ready = cpu_grant;

  regbuf_cpu_side #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .base_we(cpu_base_we), .req(cpu_req), .we(cpu_we), .wdata(cpu_wdata),
    .grant(cpu_grant), .access_req(cpu_access_req),
    .mem_addr(cpu_addr), .rvalid(cpu_rvalid)
  );

  regbuf_mem #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(i2c_tx_byte),
    .cpu_en(cpu_grant), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  // R10: ready is never offered while the bus side holds the storage.
  assert_bus_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !(bus_we || bus_re));
  // R7: read data only follows a completed processor read.
  assert_rvalid_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_ready && !cpu_we));

endmodule

// File: tb/ptr_regbuf_bench.sv
`timescale 1ns/1ps
module ptr_regbuf_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i2c_start = 0, i2c_stop = 0, i2c_addr_hit = 0, i2c_dir_rd = 0;
  logic i2c_rx_valid = 0, i2c_tx_req = 0;
  logic [DW-1:0] i2c_rx_byte = '0;
  logic [DW-1:0] i2c_tx_byte;
  logic i2c_tx_valid;
  logic cpu_base_we = 0, cpu_req = 0, cpu_we = 0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_rvalid;
  logic [DW-1:0] cpu_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptr_regbuf u_ptr_regbuf (
    .clk(clk), .rst_n(rst_n),
    .i2c_start(i2c_start), .i2c_stop(i2c_stop),
    .i2c_addr_hit(i2c_addr_hit), .i2c_dir_rd(i2c_dir_rd),
    .i2c_rx_valid(i2c_rx_valid), .i2c_rx_byte(i2c_rx_byte),
    .i2c_tx_req(i2c_tx_req), .i2c_tx_byte(i2c_tx_byte), .i2c_tx_valid(i2c_tx_valid),
    .cpu_base_we(cpu_base_we), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  // Operation codes for the vector table.
  localparam logic [3:0] SW = 4'd0, SR = 4'd1, RX = 4'd2, TX = 4'd3,
                         SP = 4'd4, CB = 4'd5, CW = 4'd6, CR = 4'd7;
  localparam int NV = 57;
  // {op, data, expected}
  localparam logic [19:0] VEC [NV] = '{
    {SW, 8'h00, 8'h00},                                          // write txn
    {RX, 8'h02, 8'h00},                                          // R2 offset 2
    {RX, 8'h11, 8'h00}, {RX, 8'h22, 8'h00},                      // R3
    {RX, 8'h33, 8'h00}, {RX, 8'h44, 8'h00},
    {SP, 8'h00, 8'h00},
    {SR, 8'h00, 8'h00},                                          // R5
    {TX, 8'h00, 8'h11}, {TX, 8'h00, 8'h22},                      // R4
    {TX, 8'h00, 8'h33}, {TX, 8'h00, 8'h44},
    {TX, 8'h00, 8'h00},                                          // R1 reset zero
    {SP, 8'h00, 8'h00},
    {SR, 8'h00, 8'h00},
    {TX, 8'h00, 8'h11},                                          // R5 repeat read
    {SP, 8'h00, 8'h00},
    {CB, 8'h02, 8'h00},                                          // R6
    {CR, 8'h00, 8'h11}, {CR, 8'h00, 8'h22},                      // R7 R1
    {CR, 8'h00, 8'h33}, {CR, 8'h00, 8'h44},
    {CR, 8'h00, 8'h00}, {CR, 8'h00, 8'h00},
    {CW, 8'hA8, 8'h00},                                          // R7 lands at 8
    {CB, 8'h08, 8'h00},
    {CR, 8'h00, 8'hA8},
    {SW, 8'h00, 8'h00},
    {RX, 8'h28, 8'h00},                                          // R9 40 -> 31
    {RX, 8'h5A, 8'h00},
    {RX, 8'h6B, 8'h00},                                          // R8 dropped
    {SP, 8'h00, 8'h00},
    {SR, 8'h00, 8'h00},
    {TX, 8'h00, 8'h5A},
    {TX, 8'h00, 8'hFF},                                          // R8 past end
    {SP, 8'h00, 8'h00},
    {CB, 8'h1F, 8'h00},
    {CR, 8'h00, 8'h5A},
    {CR, 8'h00, 8'hFF},                                          // R8 past end
    {CW, 8'h77, 8'h00},                                          // R8 dropped
    {CB, 8'h1F, 8'h00},
    {CR, 8'h00, 8'h5A},
    {CB, 8'h40, 8'h00},                                          // R9 cpu clamp
    {CR, 8'h00, 8'h5A},
    {SR, 8'h00, 8'h00},                                          // R5 base kept 31
    {TX, 8'h00, 8'h5A},
    {SP, 8'h00, 8'h00},
    {CB, 8'h00, 8'h00},
    {CW, 8'h01, 8'h00},
    {CB, 8'h00, 8'h00},
    {CR, 8'h00, 8'h01},
    {SW, 8'h00, 8'h00},
    {RX, 8'h08, 8'h00},
    {SP, 8'h00, 8'h00},
    {SR, 8'h00, 8'h00},
    {TX, 8'h00, 8'hA8},                                          // R1 cpu->bus
    {SP, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic rd);
    @(negedge clk); i2c_start = 1;
    @(negedge clk); i2c_start = 0; i2c_addr_hit = 1; i2c_dir_rd = rd;
    @(negedge clk); i2c_addr_hit = 0; i2c_dir_rd = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); i2c_stop = 1;
    @(negedge clk); i2c_stop = 0;
  endtask

  task automatic bus_rx(input logic [7:0] b);
    @(negedge clk); i2c_rx_valid = 1; i2c_rx_byte = b;
    @(negedge clk); i2c_rx_valid = 0;
  endtask

  task automatic bus_tx(input logic [7:0] exp, input string req);
    @(negedge clk); i2c_tx_req = 1;
    @(negedge clk); i2c_tx_req = 0;
    check({req, " tx_valid"}, 32'(i2c_tx_valid), 32'd1);
    check({req, " tx_byte"}, 32'(i2c_tx_byte), 32'(exp));
  endtask

  task automatic cpu_base(input logic [7:0] b);
    @(negedge clk); cpu_base_we = 1; cpu_wdata = b;
    @(negedge clk); cpu_base_we = 0;
  endtask

  task automatic cpu_access(input logic wr, input logic [7:0] b,
                            input logic [7:0] exp, input string req);
    @(negedge clk); cpu_req = 1; cpu_we = wr; cpu_wdata = b;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(negedge clk); cpu_req = 0; cpu_we = 0;
    if (!wr) begin
      check({req, " rvalid"}, 32'(cpu_rvalid), 32'd1);
      check({req, " rdata"}, 32'(cpu_rdata), 32'(exp));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1/R4/R7 reset state at the ports
    check("R4 reset tx_valid", 32'(i2c_tx_valid), 32'd0);
    check("R7 reset rvalid", 32'(cpu_rvalid), 32'd0);
    check("R10 reset ready", 32'(cpu_ready), 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:16])
        SW: pulse_start(1'b0);
        SR: pulse_start(1'b1);
        RX: bus_rx(VEC[i][15:8]);
        TX: bus_tx(VEC[i][7:0], "R4/R3/R8 vec");
        SP: pulse_stop();
        CB: cpu_base(VEC[i][15:8]);
        CW: cpu_access(1'b1, VEC[i][15:8], 8'h00, "R7 vec");
        CR: cpu_access(1'b0, 8'h00, VEC[i][7:0], "R7/R1 vec");
        default: ;
      endcase
    end

    // R10: collision, bus read in flight while processor reads location 2.
    cpu_base(8'h02);
    pulse_start(1'b1);             // bus position back to base 8
    @(negedge clk);
    i2c_tx_req = 1; cpu_req = 1; cpu_we = 0;
    #1;
    check("R10 ready low during bus access", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    i2c_tx_req = 0;
    check("R10 bus byte first", 32'(i2c_tx_byte), 32'hA8);
    #1;
    check("R10 ready after bus", 32'(cpu_ready), 32'd1);
    @(negedge clk);
    cpu_req = 0;
    check("R10 held read data", 32'(cpu_rdata), 32'h11);
    check("R10 held read valid", 32'(cpu_rvalid), 32'd1);
    pulse_stop();

    // R2: stop in the middle of a write, a new write reads offset again.
    pulse_start(1'b0);
    bus_rx(8'h0A);
    bus_rx(8'hC3);
    pulse_stop();
    pulse_start(1'b0);
    bus_rx(8'h0B);
    bus_rx(8'hD4);
    pulse_stop();
    cpu_base(8'h0A);
    cpu_access(1'b0, 8'h00, 8'hC3, "R2 first burst");
    cpu_access(1'b0, 8'h00, 8'hD4, "R2 second offset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule